// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte-wide receive stream into system memory. Memory is organised as a ring of two-word descriptors. The first word of each descriptor holds a buffer address and two flags. The second word is a status word that the block fills in. Every buffer holds exactly 128 bytes. A frame longer than that continues in the following descriptors, and the ring returns to its base after the descriptor marked as last.

Software hands a buffer to the block by clearing the ownership flag. The block hands the buffer back by setting that flag, but only after it has written the buffer's data and status. If the block needs a descriptor that software still owns, it discards the rest of the frame and raises a sticky "no buffer" indication. Clearing the receive enable stops the engine, returns the ring index to the base and clears that indication.

Top module: `rxring_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rx_ready`, `no_buf` and `mem_en` are all 0.
- R2: Byte n of a buffer (n = 0..127) is stored in the 32-bit word at byte address (address word bits 31:2, with bits 1:0 forced to 0) + 4*(n/4), in bits 8*(n%4)+7 : 8*(n%4). Both flag bits of the address word are excluded from the buffer address.
- R3: A buffer takes exactly 128 bytes. Byte 128*k of a frame starts descriptor k of that frame, and descriptor k sits at ring_base + 8*index.
- R4: Status bit 14 is set only in the frame's first descriptor, and bit 15 only in its last. Bits 11:0 hold the total frame length in bytes in the last descriptor and are 0 in every other descriptor.
- R5: In the last descriptor, status bit 31 equals the broadcast input, and bits 26, 25, 24, 23 equal `rx_match` bits 0, 1, 2, 3. Both inputs are sampled with the end-of-frame byte. These bits are 0 in every other descriptor.
- R6: When a buffer is closed, its address word is rewritten with bit 0 (ownership) set and every other bit unchanged. The data words are written first, then the status word, and then the address word.
- R7: The descriptor after one whose address word has bit 1 set is the one at ring_base.
- R8: If the descriptor at the start of a frame has bit 0 set, the whole frame is consumed and dropped, `no_buf` goes to 1, and that descriptor is left unchanged. The index does not advance, so the next frame uses the same descriptor once software has freed it.
- R9: If a frame needs a further descriptor and that descriptor has bit 0 set, the rest of the frame is dropped and `no_buf` goes to 1. Buffers that were already filled keep their data and are handed back with bit 14 set, bit 15 clear and length 0.
- R10: `no_buf` stays at 1 while `rx_en` is high. Driving `rx_en` low clears `no_buf` and moves the index back to the descriptor at ring_base.
- R11: A byte presented without the start-of-frame marker while no frame is in progress is accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive engine enable |
| ring_base | input | 32 | Byte address of descriptor 0 (bits 2:0 ignored) |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Byte accepted on this edge when high with rx_valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_bcast | input | 1 | Frame had a broadcast destination (valid with rx_eof) |
| rx_match | input | 4 | Station address 1..4 match flags (valid with rx_eof) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| no_buf | output | 1 | Sticky: a descriptor was still owned by software |

## Verification
Frames of 1, 4, 7, 128, 129 and 300 bytes are sent through a four-descriptor ring. These lengths separate a partial last word from a full one, a frame that exactly fills one buffer from one that spills a single byte, and lengths above 255. The sequence wraps the ring twice, and each frame carries a different broadcast and match pattern so that bit order errors show up in the status word. Directed cases cover stray bytes between frames, an owned descriptor at frame start and in mid-frame (the untouched descriptors hold a sentinel), and clearing the enable to check the index reset and the clearing of the sticky flag.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int BUF_BYTES = 128;
    localparam int OFF_W     = $clog2(BUF_BYTES);
    localparam int LEN_W     = 12;

    localparam int AW_OWN   = 0;
    localparam int AW_LAST  = 1;
    localparam int ST_FIRST = 14;
    localparam int ST_FINAL = 15;
    localparam int ST_BCAST = 31;
    localparam int ST_STA1  = 26;

    typedef enum logic [3:0] {
        S_IDLE, S_WSOF, S_FETCH, S_RWAIT, S_RCAP,
        S_FILL, S_WSTAT, S_WUSED, S_DROP
    } rxr_state_e;

    typedef enum logic [1:0] {WK_NONE, WK_DATA, WK_STAT, WK_USED} rxr_wkind_e;

    typedef struct packed {
        logic             first;
        logic             final_;
        logic             bcast;
        logic [3:0]       match;
        logic [LEN_W-1:0] len;
    } rxr_seg_t;

    function automatic logic [31:0] make_status(rxr_seg_t s);
        logic [31:0] w;
        w = '0;
        w[LEN_W-1:0] = s.len;
        w[ST_FIRST]  = s.first;
        w[ST_FINAL]  = s.final_;
        w[ST_BCAST]  = s.bcast;
        for (int k = 0; k < 4; k++) w[ST_STA1-k] = s.match[k];
        return w;
    endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
`timescale 1ns/1ps
module rxr_ring_ptr #(
    parameter int RING_N = 32,
    localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             last_mark,
    input  logic [31:0]      base,
    output logic [IDX_W-1:0] idx,
    output logic [31:0]      desc_addr
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            if (last_mark || idx == IDX_W'(RING_N - 1)) idx <= '0;
            else idx <= idx + 1'b1;
        end
    end

    assign desc_addr = {base[31:3], 3'b000} + (32'(idx) << 3);

    p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
        32'(idx) < RING_N);
endmodule

// File: rtl/rxr_byte_pack.sv
`timescale 1ns/1ps
module rxr_byte_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word_next
);
    logic [31:0] word_q;

    always_comb begin
        word_next = (lane == 2'd0) ? 32'h0 : word_q;
        word_next[8*lane +: 8] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else if (take) word_q <= word_next;
    end
endmodule

// File: rtl/rxring_writer.sv
`timescale 1ns/1ps
module rxring_writer
    import rxr_pkg::*;
#(
    parameter int RING_N = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic [31:0] ring_base,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_bcast,
    input  logic [3:0]  rx_match,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        no_buf
);
    localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1;

    rxr_state_e       state;
    rxr_wkind_e       wr_kind;
    rxr_seg_t         seg;
    logic [31:0]      adw;
    logic [31:0]      buf_base;
    logic [OFF_W-1:0] off;
    logic [LEN_W-1:0] frm_len;
    logic             in_frame, first_buf;
    logic [IDX_W-1:0] idx;
    logic [31:0]      desc_addr;
    logic [31:0]      pack_word;
    logic             take, ptr_adv;

    assign take    = (state == S_FILL) && rx_valid;
    assign ptr_adv = (state == S_WUSED);

    rxr_ring_ptr #(.RING_N(RING_N)) u_ptr (
        .clk(clk), .rst(rst), .clr(!rx_en), .adv(ptr_adv),
        .last_mark(adw[AW_LAST]), .base(ring_base),
        .idx(idx), .desc_addr(desc_addr)
    );

    rxr_byte_pack u_pack (
        .clk(clk), .rst(rst), .take(take), .lane(off[1:0]),
        .din(rx_data), .word_next(pack_word)
    );

    always_comb begin
        case (state)
            S_FILL, S_DROP: rx_ready = 1'b1;
            S_WSOF:         rx_ready = !rx_sof;
            default:        rx_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state     <= S_IDLE;
            wr_kind   <= WK_NONE;
            seg       <= '0;
            adw       <= '0;
            buf_base  <= '0;
            off       <= '0;
            frm_len   <= '0;
            in_frame  <= 1'b0;
            first_buf <= 1'b0;
            no_buf    <= 1'b0;
            mem_en    <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_en  <= 1'b0;
            mem_we  <= 1'b0;
            wr_kind <= WK_NONE;
            case (state)
                S_IDLE: state <= S_WSOF;
                S_WSOF: if (rx_valid && rx_sof) begin
                    in_frame  <= 1'b1;
                    first_buf <= 1'b1;
                    frm_len   <= '0;
                    state     <= S_FETCH;
                end
                S_FETCH: begin
                    mem_en   <= 1'b1;
                    mem_addr <= desc_addr;
                    state    <= S_RWAIT;
                end
                S_RWAIT: state <= S_RCAP;
                S_RCAP: begin
                    adw      <= mem_rdata;
                    buf_base <= {mem_rdata[31:2], 2'b00};
                    off      <= '0;
                    if (mem_rdata[AW_OWN]) begin
                        no_buf <= 1'b1;
                        state  <= S_DROP;
                    end else begin
                        state  <= S_FILL;
                    end
                end
                S_FILL: if (rx_valid) begin
                    frm_len <= frm_len + 1'b1;
                    off     <= off + 1'b1;
                    if (off[1:0] == 2'd3 || rx_eof) begin
                        mem_en    <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= buf_base + 32'({off[OFF_W-1:2], 2'b00});
                        mem_wdata <= pack_word;
                        wr_kind   <= WK_DATA;
                    end
                    if (rx_eof) begin
                        seg      <= '{first: first_buf, final_: 1'b1, bcast: rx_bcast,
                                      match: rx_match, len: frm_len + 1'b1};
                        in_frame <= 1'b0;
                        state    <= S_WSTAT;
                    end else if (off == OFF_W'(BUF_BYTES - 1)) begin
                        seg      <= '{first: first_buf, final_: 1'b0, bcast: 1'b0,
                                      match: 4'h0, len: '0};
                        state    <= S_WSTAT;
                    end
                end
                S_WSTAT: begin
                    mem_en    <= 1'b1;
                    mem_we    <= 1'b1;
                    mem_addr  <= desc_addr + 32'd4;
                    mem_wdata <= make_status(seg);
                    wr_kind   <= WK_STAT;
                    state     <= S_WUSED;
                end
                S_WUSED: begin
                    mem_en    <= 1'b1;
                    mem_we    <= 1'b1;
                    mem_addr  <= desc_addr;
                    mem_wdata <= adw | 32'h1;
                    wr_kind   <= WK_USED;
                    first_buf <= 1'b0;
                    state     <= in_frame ? S_FETCH : S_WSOF;
                end
                S_DROP: if (rx_valid && rx_eof) begin
                    in_frame <= 1'b0;
                    state    <= S_WSOF;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_used_after_status_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && wr_kind == WK_USED) |-> $past(mem_we && wr_kind == WK_STAT));
    p_len_only_last_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && wr_kind == WK_STAT && !mem_wdata[ST_FINAL])
            |-> mem_wdata[LEN_W-1:0] == '0);
    p_data_in_buffer_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && wr_kind == WK_DATA) |-> (mem_addr - buf_base) < BUF_BYTES);
    p_clear_on_disable_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!no_buf && !rx_ready && idx == '0));
    p_sticky_nobuf_r10: assert property (@(posedge clk) disable iff (rst)
        (no_buf && rx_en) |=> no_buf);
endmodule

// File: tb/tb_rxring_writer.sv
`timescale 1ns/1ps
module tb_rxring_writer;
    localparam logic [31:0] RB   = 32'h100;
    localparam logic [31:0] BUFB = 32'h1000;
    localparam int NDESC = 4;
    // {bcast, match[3:0], len[11:0]}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 4'b0001, 12'd1},   {1'b0, 4'b0010, 12'd4},
        {1'b0, 4'b0000, 12'd7},   {1'b0, 4'b1000, 12'd128},
        {1'b1, 4'b0100, 12'd129}, {1'b0, 4'b1111, 12'd300}
    };

    logic clk = 0, rst = 1, rx_en = 0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_bcast = 0;
    logic [7:0] rx_data = 0;
    logic [3:0] rx_match = 0;
    logic rx_ready, mem_en, mem_we, no_buf;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] mem [0:2047];
    int n_chk = 0, n_err = 0, exp_idx = 0;

    always #2.5 clk = ~clk;

    rxring_writer dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(RB),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_bcast(rx_bcast), .rx_match(rx_match),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .no_buf(no_buf)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[12:2]];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int fid, input int i);
        return 8'((fid * 37 + i) & 255);
    endfunction

    function automatic logic [31:0] daddr(input int d);
        return RB + 32'(8 * d);
    endfunction

    function automatic logic [31:0] adw_free(input int d);
        return BUFB + 32'(128 * d) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
    endfunction

    function automatic logic [31:0] exp_stat(input bit f, input bit l, input int len,
                                             input bit b, input logic [3:0] m);
        logic [31:0] s;
        s = 32'(len) & 32'hFFF;
        if (f) s |= 32'h4000;
        if (l) s |= 32'h8000;
        if (b) s |= 32'h8000_0000;
        if (m[0]) s |= 32'h0400_0000;
        if (m[1]) s |= 32'h0200_0000;
        if (m[2]) s |= 32'h0100_0000;
        if (m[3]) s |= 32'h0080_0000;
        return s;
    endfunction

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[12:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic send_frame(input int fid, input int len, input bit b, input logic [3:0] m);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_data = pat(fid, i);
            rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_bcast = rx_eof ? b : 1'b0; rx_match = rx_eof ? m : 4'h0;
            #1;
            while (!rx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_bcast = 0; rx_match = 0;
        repeat (12) @(negedge clk);
    endtask

    task automatic free_desc(input int d);
        mem[daddr(d) >> 2] = adw_free(d);
        mem[(daddr(d) >> 2) + 1] = 32'h0;
    endtask

    task automatic own_desc(input int d);
        mem[daddr(d) >> 2] = adw_free(d) | 32'h1;
        mem[(daddr(d) >> 2) + 1] = 32'hDEAD_BEEF;
    endtask

    // checks nbuf descriptors from exp_idx; bytes beyond stored are not expected
    task automatic check_frame(input int fid, input int len, input int stored,
                               input bit b, input logic [3:0] m, input bit complete);
        int nb;
        nb = (stored + 127) / 128;
        for (int k = 0; k < nb; k++) begin
            int d, cnt, bad;
            bit lastd;
            logic [7:0] got, want;
            d = exp_idx;
            lastd = complete && (k == nb - 1);
            chk(mem[(daddr(d) >> 2) + 1] ==
                exp_stat(k == 0, lastd, lastd ? len : 0, lastd && b, lastd ? m : 4'h0),
                "R4 R5 status word", mem[(daddr(d) >> 2) + 1],
                exp_stat(k == 0, lastd, lastd ? len : 0, lastd && b, lastd ? m : 4'h0));
            chk(mem[daddr(d) >> 2] == (adw_free(d) | 32'h1), "R6 ownership handed back",
                mem[daddr(d) >> 2], adw_free(d) | 32'h1);
            cnt = (stored - 128 * k > 128) ? 128 : stored - 128 * k;
            bad = -1; got = 0; want = 0;
            for (int i = 0; i < cnt; i++) begin
                if (bad < 0 && rd_byte(BUFB + 32'(128 * d + i)) != pat(fid, 128 * k + i)) begin
                    bad = i; got = rd_byte(BUFB + 32'(128 * d + i)); want = pat(fid, 128 * k + i);
                end
            end
            chk(bad < 0, "R2 R3 buffer bytes", 32'(got), 32'(want));
            free_desc(d);
            exp_idx = (exp_idx + 1) % NDESC;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        for (int d = 0; d < NDESC; d++) free_desc(d);
        repeat (3) @(negedge clk);
        // R1: during reset
        chk(!rx_ready && !no_buf && !mem_en, "R1 reset outputs", {29'b0, rx_ready, no_buf, mem_en}, 0);
        rst = 0;
        @(negedge clk);
        chk(!rx_ready && !no_buf && !mem_en, "R1 after reset", {29'b0, rx_ready, no_buf, mem_en}, 0);
        rx_en = 1;
        repeat (3) @(negedge clk);

        // table walk: R2..R7 across lengths, ring wrap twice
        for (int v = 0; v < 6; v++) begin
            send_frame(v + 1, int'(VEC[v][11:0]), VEC[v][16], VEC[v][15:12]);
            check_frame(v + 1, int'(VEC[v][11:0]), int'(VEC[v][11:0]), VEC[v][16], VEC[v][15:12], 1);
        end
        chk(exp_idx == 1, "R7 ring wrapped to base", 32'(exp_idx), 1);

        // R11: stray bytes before a frame are discarded
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_data = 8'hEE; rx_sof = 0; rx_eof = 0;
            #1;
            while (!rx_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        rx_valid = 0;
        send_frame(20, 9, 0, 4'h0);
        check_frame(20, 9, 9, 0, 4'h0, 1); // R11

        // R8: owned descriptor at frame start
        own_desc(exp_idx);
        send_frame(21, 10, 1, 4'h1);
        chk(no_buf == 1'b1, "R8 no_buf raised", 32'(no_buf), 1);
        chk(mem[(daddr(exp_idx) >> 2) + 1] == 32'hDEAD_BEEF, "R8 descriptor untouched",
            mem[(daddr(exp_idx) >> 2) + 1], 32'hDEAD_BEEF);
        free_desc(exp_idx);
        send_frame(22, 6, 0, 4'h2);
        check_frame(22, 6, 6, 0, 4'h2, 1); // R8 same descriptor reused
        chk(no_buf == 1'b1, "R10 no_buf sticky", 32'(no_buf), 1);

        // R9: owned descriptor in mid-frame
        own_desc((exp_idx + 1) % NDESC);
        send_frame(23, 200, 1, 4'hF);
        chk(mem[(daddr((exp_idx + 1) % NDESC) >> 2) + 1] == 32'hDEAD_BEEF, "R9 next descriptor untouched",
            mem[(daddr((exp_idx + 1) % NDESC) >> 2) + 1], 32'hDEAD_BEEF);
        check_frame(23, 200, 128, 0, 4'h0, 0); // R9 first buffer kept, no end flag
        free_desc(exp_idx);
        send_frame(24, 3, 0, 4'h4);
        check_frame(24, 3, 3, 0, 4'h4, 1); // R9 resumes at the freed descriptor

        // R10: disable clears flag and index
        rx_en = 0;
        repeat (3) @(negedge clk);
        rx_en = 1;
        repeat (3) @(negedge clk);
        chk(no_buf == 1'b0, "R10 no_buf cleared", 32'(no_buf), 0);
        exp_idx = 0;
        send_frame(25, 5, 1, 4'h8);
        check_frame(25, 5, 5, 1, 4'h8, 1); // R10 lands at descriptor 0

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule